// File: doc/BRIEF.md
# Funnel Shifter with Rotate

This block is a purely combinational 32-bit shifter. It covers logical right shift, arithmetic right shift, right rotate and logical left shift with a single right-extracting funnel. A mapping stage picks an upper word, a lower word and an extraction offset from the operand and the operation code. A chain of 2:1 multiplexer stages then pulls 32 contiguous bits out of the 64-bit concatenation {upper, lower}, starting at that offset. Stage k moves the vector right by 2^k positions when bit k of the offset is set.

An execution unit uses it by presenting an operand, a shift count and an operation code. The result is valid in the same cycle, with no registers in the path. The shift count is one bit wider than log2 of the data width, so a count equal to the full width can be expressed. Any larger count is clamped to the width.

There is no state machine. The block has no states and no transitions.

Top module: `funnel_shifter`

## Requirements
- R1: With operation code 2'b00 (logical right), the result equals the operand moved right by the count, with zeros entering at the most significant end.
- R2: With operation code 2'b01 (arithmetic right), the result equals the operand moved right by the count, with copies of operand bit 31 entering at the most significant end.
- R3: With operation code 2'b10 (rotate right), bits leaving the least significant end re-enter at the most significant end, so the result holds the same number of ones as the operand.
- R4: With operation code 2'b11 (logical left), the result equals the operand moved left by the count, with zeros entering at the least significant end.
- R5: A count of 0 returns the operand unchanged for every operation code.
- R6: A count of 32 gives all zeros for logical right and logical left, 32 copies of operand bit 31 for arithmetic right, and the operand unchanged for rotate right.
- R7: Any count from 33 to 63 gives the same result as a count of 32 for the same operation code.
- R8: The result is a combinational function of the inputs: it changes in the same cycle as the inputs, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | Operand to shift or rotate |
| amt_in | input | 6 | Shift count, 0 to 63 (values above 32 clamp to 32) |
| op_in | input | 2 | Operation code: 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| res_out | output | 32 | Shifted or rotated result |

## Verification
Immediate assertions inside the RTL are evaluated every time an input changes. They check properties that do not depend on the exact value of the result:
- a count of 0 returns the operand;
- a rotate keeps the number of ones;
- an arithmetic right shift keeps the sign bit;
- a non-zero logical right or left shift leaves a zero in the bit where fill enters;
- the mapped offset never exceeds the width.

The exact bit value of each result can only be shown by the directed scenarios. They compare it against an independent model across every count from 0 to 63 for each operation, on several operand patterns. Those same scenarios are the only place the clamp of counts above 32 and the same-cycle response can be seen.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

    typedef enum logic [1:0] {
        OP_SHR_LOG = 2'b00,
        OP_SHR_ARI = 2'b01,
        OP_ROT_R   = 2'b10,
        OP_SHL_LOG = 2'b11
    } shift_op_e;

endpackage

// File: rtl/funnel_map.sv
module funnel_map
    import funnel_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [SHW-1:0]   amt_in,
    input  shift_op_e        op_in,
    output logic [WIDTH-1:0] hi_word,
    output logic [WIDTH-1:0] lo_word,
    output logic [SHW-1:0]   offset
);

    localparam logic [SHW-1:0] FULL = SHW'(WIDTH);

    logic [SHW-1:0] amt_clamped;

    always_comb begin
        amt_clamped = (amt_in > FULL) ? FULL : amt_in;
    end

    always_comb begin
        unique case (op_in)
            OP_SHR_LOG: begin
                hi_word = '0;
                lo_word = a_in;
                offset  = amt_clamped;
            end
            OP_SHR_ARI: begin
                hi_word = {WIDTH{a_in[WIDTH-1]}};
                lo_word = a_in;
                offset  = amt_clamped;
            end
            OP_ROT_R: begin
                hi_word = a_in;
                lo_word = a_in;
                offset  = amt_clamped;
            end
            OP_SHL_LOG: begin
                hi_word = a_in;
                lo_word = '0;
                offset  = FULL - amt_clamped;
            end
            default: begin
                hi_word = '0;
                lo_word = a_in;
                offset  = amt_clamped;
            end
        endcase
    end

    // R7: the offset handed to the funnel stays inside the window
    always_comb begin
        p_offset_range_r7: assert (offset <= FULL)
            else $error("offset beyond width");
    end

endmodule

// File: rtl/funnel_stage.sv
module funnel_stage #(
    parameter int W2   = 64,
    parameter int DIST = 1
) (
    input  logic [W2-1:0] d_in,
    input  logic          sel,
    output logic [W2-1:0] d_out
);

    always_comb begin
        d_out = sel ? (d_in >> DIST) : d_in;
    end

endmodule

// File: rtl/funnel_extract.sv
module funnel_extract #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] hi_word,
    input  logic [WIDTH-1:0] lo_word,
    input  logic [SHW-1:0]   offset,
    output logic [WIDTH-1:0] window
);

    localparam int W2 = 2 * WIDTH;

    logic [W2-1:0] chain [SHW+1];

    always_comb begin
        chain[0] = {hi_word, lo_word};
    end

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        funnel_stage #(
            .W2   (W2),
            .DIST (1 << k)
        ) u_stage (
            .d_in  (chain[k]),
            .sel   (offset[k]),
            .d_out (chain[k+1])
        );
    end

    always_comb begin
        window = chain[SHW][WIDTH-1:0];
    end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import funnel_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [SHW-1:0]   amt_in,
    input  logic [1:0]       op_in,
    output logic [WIDTH-1:0] res_out
);

    shift_op_e      op_sel;
    logic [WIDTH-1:0] hi_word;
    logic [WIDTH-1:0] lo_word;
    logic [SHW-1:0]   offset;

    always_comb begin
        op_sel = shift_op_e'(op_in);
    end

    funnel_map #(
        .WIDTH (WIDTH),
        .SHW   (SHW)
    ) u_map (
        .a_in    (a_in),
        .amt_in  (amt_in),
        .op_in   (op_sel),
        .hi_word (hi_word),
        .lo_word (lo_word),
        .offset  (offset)
    );

    funnel_extract #(
        .WIDTH (WIDTH),
        .SHW   (SHW)
    ) u_extract (
        .hi_word (hi_word),
        .lo_word (lo_word),
        .offset  (offset),
        .window  (res_out)
    );

    always_comb begin
        // R5: zero count is identity for every operation
        if (amt_in == '0) begin
            p_zero_identity_r5: assert (res_out == a_in)
                else $error("zero count altered operand");
        end
        // R3: rotation preserves the population of ones
        if (op_sel == OP_ROT_R) begin
            p_rot_popcount_r3: assert ($countones(res_out) == $countones(a_in))
                else $error("rotate changed ones count");
        end
        // R2: arithmetic right keeps the sign
        if (op_sel == OP_SHR_ARI) begin
            p_sign_kept_r2: assert (res_out[WIDTH-1] == a_in[WIDTH-1])
                else $error("sign lost");
        end
        // R1: non-zero logical right clears the top bit
        if (op_sel == OP_SHR_LOG && amt_in != '0) begin
            p_top_zero_r1: assert (res_out[WIDTH-1] == 1'b0)
                else $error("top bit not zero-filled");
        end
        // R4: non-zero logical left clears the bottom bit
        if (op_sel == OP_SHL_LOG && amt_in != '0) begin
            p_bottom_zero_r4: assert (res_out[0] == 1'b0)
                else $error("bottom bit not zero-filled");
        end
    end

endmodule

// File: tb/sim_funnel_shifter.sv
module sim_funnel_shifter;

    logic        clk = 1'b0;
    logic [31:0] a_in;
    logic [5:0]  amt_in;
    logic [1:0]  op_in;
    logic [31:0] res_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    funnel_shifter u0 (
        .a_in    (a_in),
        .amt_in  (amt_in),
        .op_in   (op_in),
        .res_out (res_out)
    );

    function automatic logic [31:0] model(logic [31:0] a, int s, logic [1:0] op);
        int c;
        c = (s > 32) ? 32 : s;
        case (op)
            2'b00: return (c == 32) ? 32'h0 : (a >> c);
            2'b01: begin
                if (c == 32) return {32{a[31]}};
                return 32'($signed(a) >>> c);
            end
            2'b10: begin
                if (c == 0 || c == 32) return a;
                return (a >> c) | (a << (32 - c));
            end
            default: return (c == 32) ? 32'h0 : (a << c);
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] exp);
        n_run++;
        if (res_out !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d amt=%0d a=%h actual=%h expected=%h",
                     tag, op_in, amt_in, a_in, res_out, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, int s, logic [1:0] op);
        @(negedge clk);
        a_in   = a;
        amt_in = 6'(s);
        op_in  = op;
        #1;
    endtask

    task automatic sweep_op(string tag, logic [1:0] op, logic [31:0] a);
        for (int s = 0; s < 33; s++) begin
            apply(a, s, op);
            check(tag, model(a, s, op));
        end
    endtask

    task automatic t_reset_state;
        apply(32'h0, 0, 2'b00);
        check("R5 idle zero", 32'h0);
    endtask

    task automatic t_logical_right;
        sweep_op("R1", 2'b00, 32'hF00F_5AA5);
        sweep_op("R1", 2'b00, 32'hFFFF_FFFF);
    endtask

    task automatic t_arith_right;
        sweep_op("R2", 2'b01, 32'h8123_4567);
        sweep_op("R2", 2'b01, 32'h7ABC_DEF0);
    endtask

    task automatic t_rotate;
        sweep_op("R3", 2'b10, 32'h8000_0001);
        sweep_op("R3", 2'b10, 32'h1234_5678);
    endtask

    task automatic t_left;
        sweep_op("R4", 2'b11, 32'hC0DE_0003);
        sweep_op("R4", 2'b11, 32'hFFFF_FFFF);
    endtask

    task automatic t_zero_count;
        for (int op = 0; op < 4; op++) begin
            apply(32'hDEAD_BEEF, 0, 2'(op));
            check("R5", 32'hDEAD_BEEF);
        end
    endtask

    task automatic t_full_count;
        apply(32'h9000_0001, 32, 2'b00); check("R6 srl", 32'h0);
        apply(32'h9000_0001, 32, 2'b01); check("R6 sra", 32'hFFFF_FFFF);
        apply(32'h1000_0001, 32, 2'b01); check("R6 sra pos", 32'h0);
        apply(32'h9000_0001, 32, 2'b10); check("R6 ror", 32'h9000_0001);
        apply(32'h9000_0001, 32, 2'b11); check("R6 sll", 32'h0);
    endtask

    task automatic t_clamp;
        for (int s = 33; s < 64; s++) begin
            for (int op = 0; op < 4; op++) begin
                apply(32'hA5A5_0F0F, s, 2'(op));
                check("R7", model(32'hA5A5_0F0F, 32, 2'(op)));
            end
        end
    endtask

    task automatic t_same_cycle;
        apply(32'h0000_00F0, 4, 2'b00);
        check("R8 first", 32'h0000_000F);
        a_in = 32'h0000_0F00;
        #1;
        check("R8 change", 32'h0000_00F0);
        op_in = 2'b11;
        #1;
        check("R8 op change", 32'h0000_F000);
    endtask

    initial begin
        a_in   = '0;
        amt_in = '0;
        op_in  = '0;
        t_reset_state();
        t_logical_right();
        t_arith_right();
        t_rotate();
        t_left();
        t_zero_count();
        t_full_count();
        t_clamp();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule